// File: doc/BRIEF.md
# Accumulator Register-Operand Execution Unit

This block is the execution stage for register-operand and immediate instructions of a single-accumulator fixed-point audio processor. Each cycle in which an instruction is offered, the unit decodes the 32-bit word and, if the opcode belongs to its class, computes a new 24-bit accumulator (ACC). It also moves the accumulator value that was held before the instruction into the previous-accumulator register (PACC). Register operands come from a 64-entry address space: 32 general-purpose 24-bit registers at 0x20–0x3F, plus a few low addresses mapped to control-knob inputs, two audio inputs and two audio output registers.

The arithmetic covers multiply-accumulate, crossfade toward a register, store-and-scale, high and low shelving filters that mix ACC with PACC, peak detection, full multiply and scale-plus-offset. All arithmetic results clamp to the signed 24-bit range. Bitwise AND, OR and XOR with a 24-bit immediate also belong to the class, and their results are not clamped. The surrounding sequencer feeds instructions and reads ACC and PACC at the ports.

Top module: `acc_alu`

## Requirements
- R1: A synchronous active-high reset clears ACC, PACC, both audio output registers and all general-purpose registers to zero.
- R2: A class instruction (opcode bits [4:0] in 00100–01010, 01101, 01110, 01111, 10000) with instr_valid high loads PACC with the ACC value held before it. When instr_valid is low or the opcode is outside the class, ACC, PACC and every register stay unchanged.
- R3: Opcode 00100 gives ACC = ACC + C×reg. C is the signed S1.14 coefficient in bits [31:16], and reg is the register addressed by bits [10:5].
- R4: Opcode 00101 gives ACC = reg + C×(ACC − reg). With C = 0 it loads the register.
- R5: Opcode 00110 writes the old ACC to the register and gives ACC = C×ACC. A write to 0x16 or 0x17 updates audio_l_out or audio_r_out.
- R6: Opcode 00111 writes the old ACC to the register and gives ACC = PACC + C×ACC. Opcode 01000 does the same write and gives ACC = PACC + C×(PACC − ACC). With C = 0 either one swaps ACC and PACC.
- R7: Opcode 01001 gives ACC = max(|ACC|, |C×reg|). With C = 0 it is the absolute value, and the most negative ACC yields 0x7FFFFF.
- R8: Opcode 01010 gives ACC = ACC×reg in S.23. The product of −1.0 by −1.0 yields 0x7FFFFF.
- R9: Opcode 01101 gives ACC = C×ACC + offset. The offset is the signed S.10 field in bits [15:5], aligned to bit 13 of the S.23 accumulator.
- R10: Opcodes 01110, 01111 and 10000 give the AND, OR and XOR of ACC with the immediate in bits [31:8], without clamping.
- R11: Every arithmetic result is clamped to 0x7FFFFF on positive overflow and to 0x800000 on negative overflow. Coefficient products are truncated toward minus infinity.
- R12: Addresses 0x10, 0x11 and 0x12 read knob0_in, knob1_in and knob2_in. Addresses 0x14 and 0x15 read audio_l_in and audio_r_in. Addresses 0x16 and 0x17 read back the output registers. Any other address below 0x20 reads zero, and a write to it or to an input address is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction present this cycle |
| instr | input | 32 | Instruction word |
| knob0_in | input | 24 | Control knob 0 sample |
| knob1_in | input | 24 | Control knob 1 sample |
| knob2_in | input | 24 | Control knob 2 sample |
| audio_l_in | input | 24 | Left audio input sample |
| audio_r_in | input | 24 | Right audio input sample |
| acc_out | output | 24 | Accumulator |
| pacc_out | output | 24 | Previous accumulator |
| audio_l_out | output | 24 | Left audio output register |
| audio_r_out | output | 24 | Right audio output register |

## Verification
The bench drives an accumulator to both signed limits, through a coefficient of −2.0 and through the abs and square of −1.0. A design without clamping would wrap to the opposite sign there. Zero-coefficient shelf instructions must swap ACC and PACC, so a design that copied the new ACC into PACC would return the same value twice. Unmapped and input addresses are written and then read back: a design that stored into them, or returned stale data, would show a nonzero value or a changed input. Opcodes outside the class must leave both accumulators untouched, which catches a decoder that updates PACC on every valid cycle.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int DW        = 24;
    localparam int CW        = 16;
    localparam int OW        = 11;
    localparam int AW        = 6;
    localparam int PW        = 48;
    localparam int CFRAC     = CW - 2;
    localparam int DFRAC     = DW - 1;
    localparam int OFS_SHIFT = DW - OW;

    localparam logic [AW-1:0] A_KNOB0   = 6'h10;
    localparam logic [AW-1:0] A_KNOB1   = 6'h11;
    localparam logic [AW-1:0] A_KNOB2   = 6'h12;
    localparam logic [AW-1:0] A_AIN_L   = 6'h14;
    localparam logic [AW-1:0] A_AIN_R   = 6'h15;
    localparam logic [AW-1:0] A_AOUT_L  = 6'h16;
    localparam logic [AW-1:0] A_AOUT_R  = 6'h17;
    localparam logic [AW-1:0] GP_BASE   = 6'h20;

    typedef enum logic [4:0] {
        OP_MAC     = 5'b00100,
        OP_XFADE   = 5'b00101,
        OP_STORE   = 5'b00110,
        OP_HISHELF = 5'b00111,
        OP_LOSHELF = 5'b01000,
        OP_PEAK    = 5'b01001,
        OP_MUL     = 5'b01010,
        OP_SCALE   = 5'b01101,
        OP_AND     = 5'b01110,
        OP_OR      = 5'b01111,
        OP_XOR     = 5'b10000
    } opcode_e;

    typedef struct packed {
        logic                  fire;
        logic                  wr_reg;
        opcode_e               op;
        logic signed [CW-1:0]  coef;
        logic signed [OW-1:0]  offs;
        logic [AW-1:0]         addr;
        logic [DW-1:0]         imm;
    } uop_t;

    function automatic logic signed [PW-1:0] sext_d(input logic [DW-1:0] v);
        return {{(PW-DW){v[DW-1]}}, v};
    endfunction

    function automatic logic signed [PW-1:0] coef_mul(input logic signed [CW-1:0] c,
                                                      input logic signed [PW-1:0] x);
        logic signed [PW-1:0] cw;
        cw = {{(PW-CW){c[CW-1]}}, c};
        return (cw * x) >>> CFRAC;
    endfunction

    function automatic logic signed [PW-1:0] abs_w(input logic signed [PW-1:0] v);
        return v[PW-1] ? -v : v;
    endfunction

    function automatic logic [DW-1:0] sat_d(input logic signed [PW-1:0] v);
        logic signed [PW-1:0] hi;
        logic signed [PW-1:0] lo;
        hi = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
        lo = ~hi;
        if (v > hi)      return {1'b0, {(DW-1){1'b1}}};
        else if (v < lo) return {1'b1, {(DW-1){1'b0}}};
        else             return v[DW-1:0];
    endfunction

    function automatic logic addr_mapped(input logic [AW-1:0] a);
        return (a >= GP_BASE) || (a == A_KNOB0) || (a == A_KNOB1) || (a == A_KNOB2)
            || (a == A_AIN_L) || (a == A_AIN_R) || (a == A_AOUT_L) || (a == A_AOUT_R);
    endfunction

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
    import acc_alu_pkg::*;
(
    input  logic        instr_valid,
    input  logic [31:0] instr,
    output uop_t        uop
);
    logic in_class;
    logic stores;

    always_comb begin
        in_class = 1'b0;
        stores   = 1'b0;
        case (instr[4:0])
            OP_MAC, OP_XFADE, OP_PEAK, OP_MUL, OP_SCALE,
            OP_AND, OP_OR, OP_XOR:            in_class = 1'b1;
            OP_STORE, OP_HISHELF, OP_LOSHELF: begin
                in_class = 1'b1;
                stores   = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        uop.fire   = instr_valid && in_class;
        uop.wr_reg = instr_valid && stores;
        uop.op     = opcode_e'(instr[4:0]);
        uop.coef   = instr[31:16];
        uop.offs   = instr[15:5];
        uop.addr   = instr[10:5];
        uop.imm    = instr[31:8];
    end
endmodule

// File: rtl/acc_alu_regbank.sv
module acc_alu_regbank
    import acc_alu_pkg::*;
#(
    parameter int GP_COUNT = 32
)(
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] knob0,
    input  logic [DW-1:0] knob1,
    input  logic [DW-1:0] knob2,
    input  logic [DW-1:0] ain_l,
    input  logic [DW-1:0] ain_r,
    output logic [DW-1:0] aout_l,
    output logic [DW-1:0] aout_r
);
    localparam int SPACE = 1 << AW;

    logic [DW-1:0] gp_q [GP_COUNT];
    logic [DW-1:0] out_l_q;
    logic [DW-1:0] out_r_q;

    initial begin
        if (int'(GP_BASE) + GP_COUNT > SPACE)
            $error("general-purpose registers exceed the address space");
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < GP_COUNT; i++) gp_q[i] <= '0;
            out_l_q <= '0;
            out_r_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < GP_COUNT; i++)
                if (wr_addr == AW'(int'(GP_BASE) + i)) gp_q[i] <= wr_data;
            if (wr_addr == A_AOUT_L) out_l_q <= wr_data;
            if (wr_addr == A_AOUT_R) out_r_q <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_KNOB0:  rd_data = knob0;
            A_KNOB1:  rd_data = knob1;
            A_KNOB2:  rd_data = knob2;
            A_AIN_L:  rd_data = ain_l;
            A_AIN_R:  rd_data = ain_r;
            A_AOUT_L: rd_data = out_l_q;
            A_AOUT_R: rd_data = out_r_q;
            default:  ;
        endcase
        for (int i = 0; i < GP_COUNT; i++)
            if (rd_addr == AW'(int'(GP_BASE) + i)) rd_data = gp_q[i];
    end

    assign aout_l = out_l_q;
    assign aout_r = out_r_q;

    // R5: a store to the left output address lands in the output register
    a_r5_out_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_AOUT_L) |=> (out_l_q == $past(wr_data)));

    // R12: a store to an unmapped address leaves the output registers alone
    a_r12_undef_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !addr_mapped(wr_addr)) |=> ($stable(out_l_q) && $stable(out_r_q)));
endmodule

// File: rtl/acc_alu_exec.sv
module acc_alu_exec
    import acc_alu_pkg::*;
(
    input  opcode_e               op,
    input  logic signed [CW-1:0]  coef,
    input  logic signed [OW-1:0]  offs,
    input  logic [DW-1:0]         imm,
    input  logic [DW-1:0]         acc,
    input  logic [DW-1:0]         pacc,
    input  logic [DW-1:0]         rd_data,
    output logic [DW-1:0]         acc_next
);
    logic signed [PW-1:0] a_w, p_w, r_w, sum, mag_a, mag_r, ofs_w;
    logic                 bitwise;
    logic [DW-1:0]        bit_res;

    always_comb begin
        a_w     = sext_d(acc);
        p_w     = sext_d(pacc);
        r_w     = sext_d(rd_data);
        ofs_w   = {{(PW-OW){offs[OW-1]}}, offs} <<< OFS_SHIFT;
        mag_a   = abs_w(a_w);
        mag_r   = abs_w(coef_mul(coef, r_w));
        sum     = '0;
        bitwise = 1'b0;
        bit_res = '0;
        case (op)
            OP_MAC:     sum = a_w + coef_mul(coef, r_w);
            OP_XFADE:   sum = r_w + coef_mul(coef, a_w - r_w);
            OP_STORE:   sum = coef_mul(coef, a_w);
            OP_HISHELF: sum = p_w + coef_mul(coef, a_w);
            OP_LOSHELF: sum = p_w + coef_mul(coef, p_w - a_w);
            OP_PEAK:    sum = (mag_a > mag_r) ? mag_a : mag_r;
            OP_MUL:     sum = (a_w * r_w) >>> DFRAC;
            OP_SCALE:   sum = coef_mul(coef, a_w) + ofs_w;
            OP_AND: begin bitwise = 1'b1; bit_res = acc & imm; end
            OP_OR:  begin bitwise = 1'b1; bit_res = acc | imm; end
            OP_XOR: begin bitwise = 1'b1; bit_res = acc ^ imm; end
            default: sum = a_w;
        endcase
        acc_next = bitwise ? bit_res : sat_d(sum);
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int GP_COUNT = 32
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          instr_valid,
    input  logic [31:0]   instr,
    input  logic [DW-1:0] knob0_in,
    input  logic [DW-1:0] knob1_in,
    input  logic [DW-1:0] knob2_in,
    input  logic [DW-1:0] audio_l_in,
    input  logic [DW-1:0] audio_r_in,
    output logic [DW-1:0] acc_out,
    output logic [DW-1:0] pacc_out,
    output logic [DW-1:0] audio_l_out,
    output logic [DW-1:0] audio_r_out
);
    uop_t          uop;
    logic [DW-1:0] acc_q, pacc_q, acc_next, rd_data;

    acc_alu_decode u_dec (
        .instr_valid (instr_valid),
        .instr       (instr),
        .uop         (uop)
    );

    acc_alu_regbank #(.GP_COUNT(GP_COUNT)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .rd_addr (uop.addr),
        .rd_data (rd_data),
        .wr_en   (uop.wr_reg),
        .wr_addr (uop.addr),
        .wr_data (acc_q),
        .knob0   (knob0_in),
        .knob1   (knob1_in),
        .knob2   (knob2_in),
        .ain_l   (audio_l_in),
        .ain_r   (audio_r_in),
        .aout_l  (audio_l_out),
        .aout_r  (audio_r_out)
    );

    acc_alu_exec u_exec (
        .op       (uop.op),
        .coef     (uop.coef),
        .offs     (uop.offs),
        .imm      (uop.imm),
        .acc      (acc_q),
        .pacc     (pacc_q),
        .rd_data  (rd_data),
        .acc_next (acc_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            pacc_q <= '0;
        end else if (uop.fire) begin
            acc_q  <= acc_next;
            pacc_q <= acc_q;
        end
    end

    assign acc_out  = acc_q;
    assign pacc_out = pacc_q;

    // R2: PACC receives the accumulator held before the instruction
    a_r2_pacc_copy: assert property (@(posedge clk) disable iff (rst)
        uop.fire |=> (pacc_q == $past(acc_q)));

    // R2: no class instruction, no change to either accumulator
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !uop.fire |=> ($stable(acc_q) && $stable(pacc_q)));

    // R7: the peak result is never negative
    a_r7_peak_nonneg: assert property (@(posedge clk) disable iff (rst)
        (uop.fire && uop.op == OP_PEAK) |=> !acc_q[DW-1]);

    // R10: XOR result is the plain bitwise value, never clamped
    a_r10_xor_plain: assert property (@(posedge clk) disable iff (rst)
        (uop.fire && uop.op == OP_XOR) |=> (acc_q == ($past(acc_q) ^ $past(uop.imm))));
endmodule

// File: tb/acc_alu_test.sv
module acc_alu_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [23:0] knob0_in   = 24'h400000;
    logic [23:0] knob1_in   = 24'h7FFFFF;
    logic [23:0] knob2_in   = 24'h100000;
    logic [23:0] audio_l_in = 24'h200000;
    logic [23:0] audio_r_in = 24'hC00000;
    logic [23:0] acc_out, pacc_out, audio_l_out, audio_r_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    acc_alu uut (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
        .knob0_in(knob0_in), .knob1_in(knob1_in), .knob2_in(knob2_in),
        .audio_l_in(audio_l_in), .audio_r_in(audio_r_in),
        .acc_out(acc_out), .pacc_out(pacc_out),
        .audio_l_out(audio_l_out), .audio_r_out(audio_r_out)
    );

    localparam logic [4:0] K_MAC = 5'b00100, K_XF = 5'b00101, K_ST = 5'b00110,
                           K_HI = 5'b00111, K_LO = 5'b01000, K_PK = 5'b01001,
                           K_MU = 5'b01010, K_SO = 5'b01101, K_AN = 5'b01110,
                           K_OR = 5'b01111, K_XO = 5'b10000;

    function automatic logic [31:0] enc_r(input logic [4:0] op, input logic [15:0] c,
                                          input logic [5:0] a);
        return {c, 5'b00000, a, op};
    endfunction
    function automatic logic [31:0] enc_i(input logic [4:0] op, input logic [23:0] v);
        return {v, 3'b000, op};
    endfunction
    function automatic logic [31:0] enc_s(input logic [15:0] c, input logic [10:0] o);
        return {c, o, K_SO};
    endfunction

    // {requirement, instruction, expected ACC, expected PACC}
    localparam int NV = 41;
    localparam logic [87:0] VECS [NV] = '{
        {8'd10, enc_i(K_OR, 24'h100000),        24'h100000, 24'h000000}, // R10 or
        {8'd3,  enc_r(K_MAC, 16'h4000, 6'h14),  24'h300000, 24'h100000}, // R3 audio L
        {8'd3,  enc_r(K_MAC, 16'h2000, 6'h15),  24'h100000, 24'h300000}, // R3 negative reg
        {8'd5,  enc_r(K_ST, 16'hC000, 6'h20),   24'hF00000, 24'h100000}, // R5 store, invert
        {8'd4,  enc_r(K_XF, 16'h0000, 6'h20),   24'h100000, 24'hF00000}, // R4 load GP
        {8'd6,  enc_r(K_HI, 16'h0000, 6'h21),   24'hF00000, 24'h100000}, // R6 swap
        {8'd6,  enc_r(K_LO, 16'h0000, 6'h22),   24'h100000, 24'hF00000}, // R6 swap back
        {8'd6,  enc_r(K_HI, 16'h2000, 6'h23),   24'hF80000, 24'h100000}, // R6 high shelf
        {8'd6,  enc_r(K_LO, 16'h2000, 6'h24),   24'h1C0000, 24'hF80000}, // R6 low shelf
        {8'd4,  enc_r(K_XF, 16'h1000, 6'h14),   24'h1F0000, 24'h1C0000}, // R4 crossfade
        {8'd8,  enc_r(K_MU, 16'h0000, 6'h10),   24'h0F8000, 24'h1F0000}, // R8 times knob0
        {8'd7,  enc_r(K_PK, 16'h4000, 6'h15),   24'h400000, 24'h0F8000}, // R7 reg wins
        {8'd7,  enc_r(K_PK, 16'h0000, 6'h00),   24'h400000, 24'h400000}, // R7 abs positive
        {8'd10, enc_i(K_XO, 24'hFFFFFF),        24'hBFFFFF, 24'h400000}, // R10 not
        {8'd7,  enc_r(K_PK, 16'h0000, 6'h00),   24'h400001, 24'hBFFFFF}, // R7 abs negative
        {8'd10, enc_i(K_AN, 24'h0F0000),        24'h000000, 24'h400001}, // R10 and
        {8'd9,  enc_s(16'h0000, 11'h200),       24'h400000, 24'h000000}, // R9 offset only
        {8'd11, enc_s(16'h6000, 11'h100),       24'h7FFFFF, 24'h400000}, // R11 pos clamp
        {8'd3,  enc_r(K_MAC, 16'h8000, 6'h11),  24'h800001, 24'h7FFFFF}, // R3 coef -2.0
        {8'd11, enc_r(K_MAC, 16'h8000, 6'h11),  24'h800000, 24'h800001}, // R11 neg clamp
        {8'd7,  enc_r(K_PK, 16'h0000, 6'h00),   24'h7FFFFF, 24'h800000}, // R7 abs of -1.0
        {8'd11, enc_r(K_MU, 16'h0000, 6'h15),   24'hC00000, 24'h7FFFFF}, // R11 floor trunc
        {8'd10, enc_i(K_AN, 24'h000000),        24'h000000, 24'hC00000}, // R10 clear
        {8'd10, enc_i(K_OR, 24'h800000),        24'h800000, 24'h000000}, // R10 no clamp
        {8'd5,  enc_r(K_ST, 16'h4000, 6'h25),   24'h800000, 24'h800000}, // R5 unity
        {8'd8,  enc_r(K_MU, 16'h0000, 6'h25),   24'h7FFFFF, 24'h800000}, // R8 -1 x -1
        {8'd5,  enc_r(K_ST, 16'h0000, 6'h16),   24'h000000, 24'h7FFFFF}, // R5 out left
        {8'd10, enc_i(K_OR, 24'h123456),        24'h123456, 24'h000000}, // R10
        {8'd12, enc_r(K_ST, 16'h4000, 6'h08),   24'h123456, 24'h123456}, // R12 undef write
        {8'd12, enc_r(K_XF, 16'h0000, 6'h08),   24'h000000, 24'h123456}, // R12 undef read
        {8'd12, enc_r(K_XF, 16'h0000, 6'h12),   24'h100000, 24'h000000}, // R12 knob2
        {8'd12, enc_r(K_XF, 16'h0000, 6'h16),   24'h7FFFFF, 24'h100000}, // R12 out readback
        {8'd6,  enc_r(K_XF, 16'h0000, 6'h21),   24'h100000, 24'h7FFFFF}, // R6 stored reg
        {8'd6,  enc_r(K_XF, 16'h0000, 6'h24),   24'hF80000, 24'h100000}, // R6 stored reg
        {8'd2,  32'hFFFF_FFE1,                  24'hF80000, 24'h100000}, // R2 foreign op
        {8'd2,  32'h4000_002B,                  24'hF80000, 24'h100000}, // R2 foreign op
        {8'd5,  enc_r(K_ST, 16'h0000, 6'h17),   24'h000000, 24'hF80000}, // R5 out right
        {8'd10, enc_i(K_OR, 24'h0ABCDE),        24'h0ABCDE, 24'h000000}, // R10
        {8'd12, enc_r(K_ST, 16'h4000, 6'h14),   24'h0ABCDE, 24'h0ABCDE}, // R12 input write
        {8'd12, enc_r(K_XF, 16'h0000, 6'h14),   24'h200000, 24'h0ABCDE}, // R12 input intact
        {8'd9,  enc_s(16'hE000, 11'h600),       24'hB00000, 24'h200000}  // R9 neg offset
    };

    task automatic check(input string what, input int req,
                         input logic [23:0] act, input logic [23:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL R%0d %s: actual %06h expected %06h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] w);
        @(negedge clk);
        instr_valid = 1'b1;
        instr       = w;
        @(negedge clk);
        instr_valid = 1'b0;
        instr       = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        // R1: reset state
        do_reset();
        check("acc after reset", 1, acc_out, 24'h0);
        check("pacc after reset", 1, pacc_out, 24'h0);
        check("left out after reset", 1, audio_l_out, 24'h0);
        check("right out after reset", 1, audio_r_out, 24'h0);

        // R2: valid low holds everything
        @(negedge clk);
        instr       = enc_i(K_OR, 24'h777777);
        instr_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("acc with valid low", 2, acc_out, 24'h0);
        check("pacc with valid low", 2, pacc_out, 24'h0);

        // R1: general-purpose register reads zero after reset
        issue(enc_i(K_OR, 24'h555555));
        issue(enc_r(K_XF, 16'h0000, 6'h2A));
        check("gp reg after reset", 1, acc_out, 24'h0);
        check("pacc before gp load", 2, pacc_out, 24'h555555);

        do_reset();
        for (int i = 0; i < NV; i++) begin
            issue(VECS[i][79:48]);
            check($sformatf("vector %0d acc", i), int'(VECS[i][87:80]), acc_out, VECS[i][47:24]);
            check($sformatf("vector %0d pacc", i), int'(VECS[i][87:80]), pacc_out, VECS[i][23:0]);
        end
        // R5: output registers hold the stored values
        check("left out", 5, audio_l_out, 24'h7FFFFF);
        check("right out", 5, audio_r_out, 24'hF80000);

        // R1: reset in the middle of a run clears everything again
        do_reset();
        check("acc after mid reset", 1, acc_out, 24'h0);
        check("pacc after mid reset", 1, pacc_out, 24'h0);
        check("left out after mid reset", 1, audio_l_out, 24'h0);
        check("right out after mid reset", 1, audio_r_out, 24'h0);
        issue(enc_r(K_XF, 16'h0000, 6'h24));
        check("gp reg after mid reset", 1, acc_out, 24'h0);

        finish_run();
    end
endmodule